// File: doc/BRIEF.md
# Multiply-Accumulate Execute Unit

This unit sits in the execute stage of a 64-bit integer pipeline and handles a family of sixteen multiply instructions that share one 64-bit accumulator. Each instruction multiplies the low 32-bit words of two register operands. It then makes four choices. The first is whether the operands are read as signed or unsigned. The second is whether the result starts from zero or from the current accumulator. The third is whether the product is added or subtracted. The fourth is which 32-bit half of the new accumulator is returned for the destination register.

The accumulator is one 64-bit register. It is exposed as two 64-bit architectural views, a high view and a low view. Each view holds one 32-bit half in its low word, and its upper word is filled with copies of that half's sign bit. The pipeline presents an instruction word and two operands with `valid_i`. Exactly one cycle later the unit raises `done_o`. With it comes either a destination write (address and sign-extended data) or an illegal-operation flag.

Top module: `mac_exec_unit`

## Requirements
- R1: An instruction is legal when bits [31:26] are 000000, bits [5:0] are 011000 (signed) or 011001 (unsigned), and the five-bit field [10:6] has bit 0 set and bit 4 clear. Within that field, bit 3 selects the high half for the destination, bit 2 starts from the accumulator instead of zero, and bit 1 subtracts the product instead of adding it.
- R2: A signed instruction sign-extends both 32-bit operands to 64 bits before it multiplies. An unsigned instruction zero-extends them.
- R3: The new accumulator is the base value (zero or the current accumulator) plus or minus the 64-bit product, computed modulo 2^64.
- R4: `hi_o` carries accumulator bits [63:32] and `lo_o` carries bits [31:0]. Each is sign-extended to 64 bits. After reset both read zero.
- R5: On a write, `rd_data_o` is the selected half of the updated accumulator, sign-extended to 64 bits. This holds for unsigned instructions too.
- R6: `done_o` is high exactly in the cycle after each cycle in which `valid_i` is high. For a legal instruction, `wr_en_o` is high with `done_o`, and `rd_addr_o` holds instruction bits [15:11].
- R7: For an illegal instruction, `illegal_o` is high with `done_o`, `wr_en_o` stays low, and the accumulator keeps its value.
- R8: While reset is asserted, `done_o`, `wr_en_o` and `illegal_o` are low and the accumulator is zero.
- R9: In a cycle with `valid_i` low, the accumulator keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction and operands are present |
| instr_i | input | 32 | Instruction word |
| op_a_i | input | 32 | Low word of the first source register |
| op_b_i | input | 32 | Low word of the second source register |
| done_o | output | 1 | Result of the previous valid cycle |
| wr_en_o | output | 1 | Destination write enable |
| rd_addr_o | output | 5 | Destination register index |
| rd_data_o | output | 64 | Destination value |
| illegal_o | output | 1 | Previous instruction was not recognised |
| hi_o | output | 64 | High accumulator view |
| lo_o | output | 64 | Low accumulator view |

## Verification
The assertions check the following on every cycle:
- the one-cycle response timing;
- that a response is either a write or an illegal flag, never both;
- that the accumulator holds across idle and illegal cycles;
- that the accumulator views and the destination value are sign-extended and agree with each other.

None of these properties can tell whether the arithmetic is right. Sign and zero extension of the operands, correct negation, wrap-around at 2^64, and whether a given encoding picks the right half only show up in the bench. The bench compares all sixteen variants against a behavioural 64-bit model with extreme operands and runs long accumulate chains.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam logic [5:0] MAJOR_SPECIAL = 6'b000000;
  localparam logic [5:0] FN_MUL_S      = 6'b011000;
  localparam logic [5:0] FN_MUL_U      = 6'b011001;

  typedef struct packed {
    logic legal;
    logic is_signed;
    logic use_acc;
    logic subtract;
    logic sel_hi;
  } mac_op_t;
endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
(
  input  logic [5:0] major_i,
  input  logic [4:0] mode_i,
  input  logic [5:0] func_i,
  output mac_op_t    op_o
);
  logic fn_ok, mode_ok;

  assign fn_ok   = (func_i == FN_MUL_S) || (func_i == FN_MUL_U);
  assign mode_ok = mode_i[0] && !mode_i[4];

  always_comb begin
    op_o.legal     = (major_i == MAJOR_SPECIAL) && fn_ok && mode_ok;
    op_o.is_signed = (func_i == FN_MUL_S);
    op_o.sel_hi    = mode_i[3];
    op_o.use_acc   = mode_i[2];
    op_o.subtract  = mode_i[1];
  end
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int OP_W = 32,
  localparam int PROD_W = 2 * OP_W
) (
  input  logic              is_signed_i,
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic [PROD_W-1:0] prod_o
);
  // One guard bit makes a single signed multiplier cover both signednesses
  logic signed [OP_W:0]     a_ext, b_ext;
  logic signed [PROD_W+1:0] full;

  assign a_ext  = {is_signed_i & a_i[OP_W-1], a_i};
  assign b_ext  = {is_signed_i & b_i[OP_W-1], b_i};
  assign full   = a_ext * b_ext;
  assign prod_o = full[PROD_W-1:0];

  logic unused_guard;
  assign unused_guard = ^full[PROD_W+1:PROD_W];
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int ACC_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             valid_i,
  input  mac_op_t          op_i,
  input  logic [ACC_W-1:0] prod_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [ACC_W-1:0] acc_nxt_o
);
  logic [ACC_W-1:0] acc_q, base, addend;

  assign base      = op_i.use_acc ? acc_q : '0;
  assign addend    = op_i.subtract ? (~prod_i + 1'b1) : prod_i;
  assign acc_nxt_o = base + addend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (upd_i) acc_q <= acc_nxt_o;
  end

  assign acc_o = acc_q;

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(acc_q));
  // R7
  illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_i.legal) |=> $stable(acc_q));
endmodule

// File: rtl/mac_exec_unit.sv
module mac_exec_unit
  import mac_pkg::*;
#(
  parameter int OP_W = 32,
  parameter int XLEN = 64,
  localparam int ACC_W = 2 * OP_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  input  logic [OP_W-1:0] op_a_i,
  input  logic [OP_W-1:0] op_b_i,
  output logic            done_o,
  output logic            wr_en_o,
  output logic [4:0]      rd_addr_o,
  output logic [XLEN-1:0] rd_data_o,
  output logic            illegal_o,
  output logic [XLEN-1:0] hi_o,
  output logic [XLEN-1:0] lo_o
);
  localparam int EXT_W = XLEN - OP_W;

  mac_op_t          op;
  logic [ACC_W-1:0] prod, acc, acc_nxt;
  logic [OP_W-1:0]  half_nxt;
  logic             upd;

  mac_decode u_decode (
    .major_i (instr_i[31:26]),
    .mode_i  (instr_i[10:6]),
    .func_i  (instr_i[5:0]),
    .op_o    (op)
  );

  mac_mult #(.OP_W(OP_W)) u_mult (
    .is_signed_i (op.is_signed),
    .a_i         (op_a_i),
    .b_i         (op_b_i),
    .prod_o      (prod)
  );

  assign upd = valid_i && op.legal;

  mac_accum #(.ACC_W(ACC_W)) u_accum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (upd),
    .valid_i   (valid_i),
    .op_i      (op),
    .prod_i    (prod),
    .acc_o     (acc),
    .acc_nxt_o (acc_nxt)
  );

  assign half_nxt = op.sel_hi ? acc_nxt[ACC_W-1:OP_W] : acc_nxt[OP_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      wr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
      rd_addr_o <= '0;
      rd_data_o <= '0;
    end else begin
      done_o    <= valid_i;
      wr_en_o   <= upd;
      illegal_o <= valid_i && !op.legal;
      if (upd) begin
        rd_addr_o <= instr_i[15:11];
        rd_data_o <= {{EXT_W{half_nxt[OP_W-1]}}, half_nxt};
      end
    end
  end

  assign hi_o = {{EXT_W{acc[ACC_W-1]}}, acc[ACC_W-1:OP_W]};
  assign lo_o = {{EXT_W{acc[OP_W-1]}}, acc[OP_W-1:0]};

  logic unused_fields;
  assign unused_fields = ^instr_i[25:16];

  // R6
  done_follows_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  // R6
  no_spurious_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  // R7
  resp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (wr_en_o ^ illegal_o));
  // R5
  rd_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (rd_data_o == hi_o || rd_data_o == lo_o));
  // R4
  view_canon_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_o[XLEN-1:OP_W] == {EXT_W{hi_o[OP_W-1]}}) &&
    (lo_o[XLEN-1:OP_W] == {EXT_W{lo_o[OP_W-1]}}));
  // R8
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!done_o && !wr_en_o && !illegal_o && acc == '0));
endmodule

// File: tb/mac_exec_unit_tb_top.sv
module mac_exec_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] op_a_i = '0, op_b_i = '0;
  logic        done_o, wr_en_o, illegal_o;
  logic [4:0]  rd_addr_o;
  logic [63:0] rd_data_o, hi_o, lo_o;

  int tests = 0, fails = 0;
  bit finished = 0;
  string tag = "R8";

  // behavioural model state
  logic [63:0] m_acc = '0;
  bit          e_done = 0, e_wr = 0, e_ill = 0;
  logic [4:0]  e_addr = '0;
  logic [63:0] e_data = '0;

  always #10 clk_i = ~clk_i;

  mac_exec_unit dut_i (.*);

  function automatic logic [31:0] mk(int mode, bit uns, int rd);
    logic [4:0] m = mode[4:0];
    logic [4:0] d = rd[4:0];
    return {6'b000000, 5'd3, 5'd4, d, m, uns ? 6'b011001 : 6'b011000};
  endfunction

  function automatic logic [63:0] sx(logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(done_o == e_done, "R6", "done", 64'(done_o), 64'(e_done));
    chk(wr_en_o == e_wr, "R6", "wr_en", 64'(wr_en_o), 64'(e_wr));
    chk(illegal_o == e_ill, "R7", "illegal", 64'(illegal_o), 64'(e_ill));
    if (e_wr) begin
      chk(rd_addr_o == e_addr, "R6", "rd_addr", 64'(rd_addr_o), 64'(e_addr));
      chk(rd_data_o == e_data, tag == "R4" ? "R5" : tag, "rd_data", rd_data_o, e_data);
    end
    chk(hi_o == sx(m_acc[63:32]), "R4", "hi", hi_o, sx(m_acc[63:32]));
    chk(lo_o == sx(m_acc[31:0]), "R4", "lo", lo_o, sx(m_acc[31:0]));
  endtask

  // drive one cycle, update the model, compare after the edge
  task automatic step(bit v, logic [31:0] ins, logic [31:0] a, logic [31:0] b);
    bit legal, hi_sel, use_acc, sub, sgn;
    logic [63:0] p, base, nxt;
    valid_i = v; instr_i = ins; op_a_i = a; op_b_i = b;
    legal = (ins[31:26] == 0) && (ins[5:0] == 6'h18 || ins[5:0] == 6'h19) &&
            (ins[10:6] inside {5'd1, 5'd3, 5'd5, 5'd7, 5'd9, 5'd11, 5'd13, 5'd15});
    sgn     = (ins[5:0] == 6'h18);
    hi_sel  = ins[10:6] inside {5'd9, 5'd11, 5'd13, 5'd15};
    use_acc = ins[10:6] inside {5'd5, 5'd7, 5'd13, 5'd15};
    sub     = ins[10:6] inside {5'd3, 5'd7, 5'd11, 5'd15};
    p = sgn ? (sx(a) * sx(b)) : ({32'd0, a} * {32'd0, b});
    base = use_acc ? m_acc : 64'd0;
    nxt  = sub ? base - p : base + p;
    e_done = v;
    e_wr   = v && legal;
    e_ill  = v && !legal;
    if (v && legal) begin
      e_addr = ins[15:11];
      e_data = hi_sel ? sx(nxt[63:32]) : sx(nxt[31:0]);
    end
    @(posedge clk_i);
    if (v && legal) m_acc = nxt;
    @(negedge clk_i);
    compare();
    valid_i = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    tests++; fails++;
    $display("FAIL watchdog expired act=%h exp=%h", 64'd0, 64'd1);
    summary();
  end

  logic [31:0] pat [8] = '{32'h0000_0000, 32'h0000_0001, 32'h8000_0000, 32'hFFFF_FFFF,
                           32'h7FFF_FFFF, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0001_0000};

  initial begin
    logic [31:0] lfsr = 32'hACE1_1234;
    // R8: reset state
    repeat (3) @(negedge clk_i);
    compare();
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare();

    // R1 R2 R3 R5: every variant across extreme operand pairs
    tag = "R2";
    for (int m = 1; m < 16; m += 2)
      for (int u = 0; u < 2; u++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j += 3)
            step(1, mk(m, u[0], i * 4 + j), pat[i], pat[j]);

    // R5: unsigned result with high bit set still sign-extends
    tag = "R5";
    step(1, mk(1, 1, 7), 32'hFFFF_FFFF, 32'h8000_0000);
    step(1, mk(9, 1, 8), 32'hFFFF_FFFF, 32'hFFFF_FFFF);

    // R9: idle cycles leave the accumulator
    tag = "R9";
    repeat (4) step(0, mk(5, 0, 1), 32'h1111_1111, 32'h2222_2222);

    // R7: illegal encodings
    tag = "R7";
    step(1, mk(0, 0, 3), 32'h5, 32'h7);
    step(1, mk(17, 0, 3), 32'h5, 32'h7);
    step(1, mk(5, 0, 3) | 32'h0000_0002, 32'h5, 32'h7);
    step(1, mk(5, 1, 3) | 32'h0400_0000, 32'h5, 32'h7);
    step(1, mk(2, 0, 3), 32'h5, 32'h7);
    step(1, mk(1, 0, 4), 32'h3, 32'h3);

    // R3: long wrapping accumulate/subtract chains
    tag = "R3";
    step(1, mk(1, 1, 9), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    repeat (40) step(1, mk(5, 1, 10), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    repeat (40) step(1, mk(15, 0, 11), 32'h8000_0000, 32'h7FFF_FFFF);
    repeat (40) step(1, mk(13, 0, 12), 32'h8000_0000, 32'h8000_0000);

    // R1: pseudo-random mix of legal and illegal words
    tag = "R1";
    for (int k = 0; k < 300; k++) begin
      logic [31:0] w;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      w = mk(int'(lfsr[4:0]) & 32'h0F | 1, lfsr[5], int'(lfsr[10:6]));
      if (lfsr[13:11] == 0) w[10:6] = lfsr[20:16];
      step(lfsr[14] | lfsr[15], w, lfsr ^ 32'h9E37_79B9, {lfsr[15:0], lfsr[31:16]});
    end
    summary();
  end
endmodule